// File: doc/BRIEF.md
# Multichannel Mains-Cancelling Sample Averager

This block sits behind an eight-way multiplexed converter front end. It produces a sample strobe whose rate is exactly four times the power-line frequency, either 240 Hz for 60 Hz systems or 200 Hz for 50 Hz systems. It collects the tagged conversion results that come back and averages each channel's results in groups of four. The four samples of a group fall a quarter of a mains cycle apart, so they form two pairs of opposite polarity. The line-frequency interference therefore cancels in the sum, and the average carries only the wanted signal.

Each channel has its own accumulator and sample counter, so results from different channels may arrive in any interleaving. A channel switch therefore costs no settling time, and the first group of four on a channel is already a valid output. When a group completes, the block issues a one-cycle result pulse with the channel number and the averaged value. Changing the mains-mode select throws away all partial groups and restarts the strobe timing.

Top module: `mains_sync_averager`

## Requirements
- R1: With `mode_sel` = 0 (60 Hz mains), `smp_strobe` is high for one cycle every REF_HZ/240 clock cycles.
- R2: With `mode_sel` = 1 (50 Hz mains), `smp_strobe` is high for one cycle every REF_HZ/200 clock cycles.
- R3: For each channel, every fourth accepted result completes a group. The output value is the 18-bit signed sum of the four 16-bit two's complement samples, shifted arithmetically right by 2 (rounding toward minus infinity), taken as 16-bit two's complement.
- R4: `avg_valid` is high for exactly one cycle, in the cycle after the clock edge that accepts a group's fourth result. `avg_chan` then equals that result's `res_chan` value (0 to 7).
- R5: The channels accumulate independently. Results on other channels between two results on one channel do not change that channel's sum. The first group on a channel after switching to it is output with no samples discarded.
- R6: When `mode_sel` differs from its value in the previous cycle, any result presented in that cycle is discarded, all partial groups are cleared, and no result is produced in the next cycle. The next strobe comes N cycles after that cycle, where N is the new mode's period.
- R7: While reset is active, `smp_strobe`, `avg_valid`, `avg_chan` and `avg_data` are all 0.
- R8: A group of samples b+m, b+k, b−m, b−k (a mains component at four quarter-cycle phases around a level b) produces exactly b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_sel | input | 1 | Mains select: 0 = 60 Hz (240 Hz strobe), 1 = 50 Hz (200 Hz strobe) |
| res_valid | input | 1 | A conversion result is presented this cycle |
| res_chan | input | 3 | Channel number of the presented result |
| res_data | input | 16 | Signed conversion result |
| smp_strobe | output | 1 | One-cycle sample request to the front end |
| avg_valid | output | 1 | One-cycle pulse: averaged result available |
| avg_chan | output | 3 | Channel number of the averaged result |
| avg_data | output | 16 | Signed average of four samples |

## Verification
Full-scale positive and negative groups show whether the 18-bit sum and the arithmetic shift are right. A group summing to −1 separates flooring from truncation toward zero. Groups of a level plus opposite-phase mains terms show that the quarter-cycle pairs cancel exactly. Interleaved random channels and values with random gaps separate truly independent accumulators from ones that leak into each other or drop samples on a channel switch. Mode flips, including one that coincides with a result, show whether partial groups are cleared and whether the strobe restarts with the new period.

// File: rtl/msa_pkg.sv
package msa_pkg;

  typedef enum logic {
    MAINS_60 = 1'b0,
    MAINS_50 = 1'b1
  } mains_e;

  // clock cycles between sample strobes for a given line frequency
  function automatic int strobe_div(input int ref_hz, input int line_hz, input int grp);
    return ref_hz / (line_hz * grp);
  endfunction

endpackage

// File: rtl/msa_rst_sync.sv
module msa_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic q1, q2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q1 <= 1'b0;
      q2 <= 1'b0;
    end else begin
      q1 <= 1'b1;
      q2 <= q1;
    end
  end

  assign rst_n_s = q2;
endmodule

// File: rtl/msa_strobe_gen.sv
module msa_strobe_gen #(
  parameter int DIV_A = 10,
  parameter int DIV_B = 12,
  parameter int CNTW  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_b,
  input  logic restart,
  output logic strobe
);
  logic [CNTW-1:0] cnt_q, cnt_d, lim;

  assign lim = sel_b ? CNTW'(DIV_B - 1) : CNTW'(DIV_A - 1);

  always_comb begin
    if (restart)          cnt_d = '0;
    else if (cnt_q >= lim) cnt_d = '0;
    else                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign strobe = (cnt_q == lim) && !restart;
endmodule

// File: rtl/msa_chan_acc.sv
module msa_chan_acc #(
  parameter int DW  = 16,
  parameter int AW  = 18,
  parameter int GRP = 4,
  parameter int GW  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          hit,
  input  logic [DW-1:0] din,
  output logic          done,
  output logic [AW-1:0] sum
);
  logic [AW-1:0] acc_q, acc_d;
  logic [GW-1:0] cnt_q, cnt_d;
  logic          acc_en;

  assign sum  = acc_q + {{(AW-DW){din[DW-1]}}, din};
  assign done = hit && (cnt_q == GW'(GRP - 1));

  assign acc_en = clr || hit;

  always_comb begin
    acc_d = acc_q;
    cnt_d = cnt_q;
    if (clr || done) begin
      acc_d = '0;
      cnt_d = '0;
    end else if (hit) begin
      acc_d = sum;
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/msa_out_stage.sv
module msa_out_stage #(
  parameter int N_CH  = 8,
  parameter int CW    = 3,
  parameter int DW    = 16,
  parameter int AW    = 18,
  parameter int SHIFT = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_CH-1:0]          done,
  input  logic [N_CH-1:0][AW-1:0]  sums,
  output logic                     avg_valid,
  output logic [CW-1:0]            avg_chan,
  output logic [DW-1:0]            avg_data
);
  logic [AW-1:0]        sel_sum;
  logic signed [AW-1:0] shifted;
  logic [CW-1:0]        sel_chan;
  logic                 any_done;

  always_comb begin
    sel_sum  = '0;
    sel_chan = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (done[i]) begin
        sel_sum  = sums[i];
        sel_chan = CW'(i);
      end
    end
  end

  assign any_done = |done;
  assign shifted  = $signed(sel_sum) >>> SHIFT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) avg_valid <= 1'b0;
    else        avg_valid <= any_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      avg_chan <= '0;
      avg_data <= '0;
    end else if (any_done) begin
      avg_chan <= sel_chan;
      avg_data <= shifted[DW-1:0];
    end
  end
endmodule

// File: rtl/mains_sync_averager.sv
module mains_sync_averager #(
  parameter int N_CH   = 8,
  parameter int DW     = 16,
  parameter int GRP    = 4,
  parameter int REF_HZ = 1200000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mode_sel,
  input  logic                    res_valid,
  input  logic [$clog2(N_CH)-1:0] res_chan,
  input  logic [DW-1:0]           res_data,
  output logic                    smp_strobe,
  output logic                    avg_valid,
  output logic [$clog2(N_CH)-1:0] avg_chan,
  output logic [DW-1:0]           avg_data
);
  import msa_pkg::*;

  localparam int CW    = $clog2(N_CH);
  localparam int SHIFT = $clog2(GRP);
  localparam int GW    = (SHIFT > 0) ? SHIFT : 1;
  localparam int AW    = DW + SHIFT;
  localparam int DIV60 = strobe_div(REF_HZ, 60, GRP);
  localparam int DIV50 = strobe_div(REF_HZ, 50, GRP);
  localparam int DMAX  = (DIV60 > DIV50) ? DIV60 : DIV50;
  localparam int CNTW  = $clog2(DMAX + 1);

  logic   rst_n_s;
  mains_e mode_q;
  logic   mode_chg;
  logic [N_CH-1:0]         hit, done;
  logic [N_CH-1:0][AW-1:0] sums;

  msa_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) mode_q <= MAINS_60;
    else          mode_q <= mains_e'(mode_sel);
  end

  assign mode_chg = (mains_e'(mode_sel) != mode_q);

  msa_strobe_gen #(
    .DIV_A (DIV60),
    .DIV_B (DIV50),
    .CNTW  (CNTW)
  ) u_strobe (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .sel_b   (mode_q == MAINS_50),
    .restart (mode_chg),
    .strobe  (smp_strobe)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_chan
    assign hit[g] = res_valid && !mode_chg && (res_chan == CW'(g));

    msa_chan_acc #(
      .DW  (DW),
      .AW  (AW),
      .GRP (GRP),
      .GW  (GW)
    ) u_acc (
      .clk   (clk),
      .rst_n (rst_n_s),
      .clr   (mode_chg),
      .hit   (hit[g]),
      .din   (res_data),
      .done  (done[g]),
      .sum   (sums[g])
    );
  end

  msa_out_stage #(
    .N_CH  (N_CH),
    .CW    (CW),
    .DW    (DW),
    .AW    (AW),
    .SHIFT (SHIFT)
  ) u_out (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .done      (done),
    .sums      (sums),
    .avg_valid (avg_valid),
    .avg_chan  (avg_chan),
    .avg_data  (avg_data)
  );
endmodule

// File: rtl/msa_checker.sv
module msa_checker #(
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_ns,
  input logic          mode_sel,
  input logic          res_valid,
  input logic [CW-1:0] res_chan,
  input logic          smp_strobe,
  input logic          avg_valid,
  input logic [CW-1:0] avg_chan
);
  // R1 / R2: strobe is a single-cycle pulse
  assert_strobe_pulse_R1: assert property (@(posedge clk) disable iff (!rst_ns)
    smp_strobe |=> !smp_strobe);

  // R4: a result pulse follows an accepted result on the same channel
  assert_out_follows_in_R4: assert property (@(posedge clk) disable iff (!rst_ns)
    avg_valid |-> ($past(res_valid) && avg_chan == $past(res_chan)));

  // R4: back-to-back pulses only come from different channels
  assert_one_cycle_pulse_R4: assert property (@(posedge clk) disable iff (!rst_ns)
    avg_valid |=> (!avg_valid || avg_chan != $past(avg_chan)));

  // R6: a mode change suppresses any result in the following cycle
  assert_mode_change_flush_R6: assert property (@(posedge clk) disable iff (!rst_ns)
    (mode_sel != $past(mode_sel)) |=> !avg_valid);
endmodule

bind mains_sync_averager msa_checker #(.CW($clog2(N_CH))) u_chk (
  .clk        (clk),
  .rst_ns     (rst_n_s),
  .mode_sel   (mode_sel),
  .res_valid  (res_valid),
  .res_chan   (res_chan),
  .smp_strobe (smp_strobe),
  .avg_valid  (avg_valid),
  .avg_chan   (avg_chan)
);

// File: tb/mains_sync_averager_tb.sv
`timescale 1ns/1ps
module mains_sync_averager_tb;
  localparam int REF_HZ = 2400;
  localparam int DIV60  = REF_HZ / 240;
  localparam int DIV50  = REF_HZ / 200;

  logic        clk = 1'b0;
  logic        rst_n, mode_sel, res_valid;
  logic [2:0]  res_chan;
  logic [15:0] res_data;
  logic        smp_strobe, avg_valid;
  logic [2:0]  avg_chan;
  logic [15:0] avg_data;

  int n_chk = 0;
  int n_fail = 0;
  int m_sum [8];
  int m_cnt [8];
  int seed_dummy;

  always #2.5 clk = ~clk;

  mains_sync_averager #(.REF_HZ(REF_HZ)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .res_valid(res_valid),
    .res_chan(res_chan), .res_data(res_data), .smp_strobe(smp_strobe),
    .avg_valid(avg_valid), .avg_chan(avg_chan), .avg_data(avg_data)
  );

  function automatic logic [15:0] exp_avg(input int s);
    int q;
    q = s >>> 2;
    return q[15:0];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic clear_model();
    for (int i = 0; i < 8; i++) begin
      m_sum[i] = 0;
      m_cnt[i] = 0;
    end
  endtask

  // call at a negedge; presents one result and checks the cycle after
  task automatic send(input int ch, input int val, input string req);
    int  s;
    bit  fin;
    res_valid = 1'b1;
    res_chan  = ch[2:0];
    res_data  = val[15:0];
    m_sum[ch] += val;
    m_cnt[ch]++;
    fin = (m_cnt[ch] == 4);
    s   = m_sum[ch];
    if (fin) begin
      m_sum[ch] = 0;
      m_cnt[ch] = 0;
    end
    @(negedge clk);
    res_valid = 1'b0;
    if (fin) begin
      chk(avg_valid == 1'b1, req, int'(avg_valid), 1);
      chk(avg_chan == ch[2:0], req, int'(avg_chan), ch);
      chk(avg_data == exp_avg(s), req, int'($signed(avg_data)), int'($signed(exp_avg(s))));
    end else begin
      chk(avg_valid == 1'b0, req, int'(avg_valid), 0);
    end
  endtask

  task automatic wait_strobe(output int k);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!smp_strobe && k < 1000);
  endtask

  initial begin
    int k;
    seed_dummy = $urandom(32'h5EED_0021);
    clear_model();
    rst_n = 1'b0; mode_sel = 1'b0; res_valid = 1'b0; res_chan = '0; res_data = '0;
    repeat (4) @(negedge clk);
    // R7: reset state
    chk(smp_strobe == 1'b0, "R7 strobe", int'(smp_strobe), 0);
    chk(avg_valid == 1'b0, "R7 valid", int'(avg_valid), 0);
    chk(avg_chan == 3'd0, "R7 chan", int'(avg_chan), 0);
    chk(avg_data == 16'd0, "R7 data", int'(avg_data), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: 60 Hz strobe period
    wait_strobe(k);
    for (int r = 0; r < 2; r++) begin
      wait_strobe(k);
      chk(k == DIV60, "R1 period", k, DIV60);
    end

    // R3: full-scale and flooring corners on channel 0
    for (int i = 0; i < 4; i++) send(0, 32767, "R3 max");
    for (int i = 0; i < 4; i++) send(0, -32768, "R3 min");
    send(0, -1, "R3 floor"); send(0, 0, "R3 floor");
    send(0, 0, "R3 floor");  send(0, 0, "R3 floor");
    // R4: no second pulse on the idle cycle after completion
    @(negedge clk);
    chk(avg_valid == 1'b0, "R4 single pulse", int'(avg_valid), 0);

    // R8: level plus quarter-phase mains terms cancels to the level
    send(2, 1000 + 500, "R8"); send(2, 1000 - 300, "R8");
    send(2, 1000 - 500, "R8"); send(2, 1000 + 300, "R8");
    chk(avg_data == 16'd1000, "R8 cancel", int'($signed(avg_data)), 1000);
    send(7, -2000 + 900, "R8"); send(7, -2000 + 50, "R8");
    send(7, -2000 - 900, "R8"); send(7, -2000 - 50, "R8");

    // R5: interleaving and channel switching
    send(3, 111, "R5"); send(3, -222, "R5");
    for (int i = 0; i < 4; i++) send(4, 4000 + i, "R5 switch");
    send(3, 333, "R5"); send(3, 444, "R5");

    // R6 and R2: mode flip restarts strobe with the 50 Hz period
    mode_sel = 1'b1;
    clear_model();
    wait_strobe(k);
    chk(k == DIV50, "R6 restart", k, DIV50);
    for (int r = 0; r < 2; r++) begin
      wait_strobe(k);
      chk(k == DIV50, "R2 period", k, DIV50);
    end

    // R6: result in the flip cycle is dropped, partial groups cleared
    send(1, 7000, "R6 partial"); send(1, 7000, "R6 partial");
    mode_sel = 1'b0;
    res_valid = 1'b1; res_chan = 3'd1; res_data = 16'd7000;
    @(negedge clk);
    res_valid = 1'b0;
    chk(avg_valid == 1'b0, "R6 flip cycle", int'(avg_valid), 0);
    clear_model();
    send(1, 8, "R6 cleared"); send(1, 8, "R6 cleared");
    send(1, 8, "R6 cleared"); send(1, 12, "R6 cleared");

    // R5 / R3: random interleaved traffic
    for (int n = 0; n < 400; n++) begin
      logic signed [15:0] r;
      int ch;
      r  = 16'($urandom);
      ch = int'($urandom % 8);
      send(ch, int'(r), "R5 random");
      if (($urandom % 4) == 0) begin
        @(negedge clk);
        chk(avg_valid == 1'b0, "R4 idle", int'(avg_valid), 0);
      end
    end

    report();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end
endmodule